// File: doc/BRIEF.md
# Display Controller Register Bank

This block is the register front end of a display controller. A CPU reaches it through a simple request port. It stores the panel sizes, the graphics-layer parameters, the colour keys and the timing words. It folds an event status register and an event enable register into one level interrupt. It drives the LCD and digital output enable lines from the control register. A frame-done pulse from the display pipeline sets a status bit.

Any write that changes what ends up on screen raises a single-cycle invalidate strobe, so the pipeline knows to redraw. Examples are a size, a colour, a base address or a layer attribute. A write with bit 1 set in the system configuration register resets all state in software. Reads are combinational: `rspRdata` is valid in the same cycle as a read request.

Only aligned 32-bit accesses take effect. Narrow, misaligned and undefined accesses are ignored on write and read as zero. The video-layer window is one of these undefined ranges.

Top module: `dispreg_top`

## Requirements
- R1: Only aligned word accesses take effect. An aligned word access has `reqSize` code 2 and address bits 1:0 at zero. Any other size or alignment, offset 0x7C, and every offset from 0x80 upward change no state on write and read as zero. The upper range includes the video-layer window 0x100–0x1FF.
- R2: Some offsets read fixed values: offset 0x00 reads 0x20 (identification), 0x08 reads 1 (module status), 0x30 reads 0x7FF (line status) and 0x68 reads 256 (graphics FIFO status). Writes to these offsets change nothing.
- R3: After reset:
  - the capability register (0x1C) reads 0x161;
  - the row increment (0x6C) and pixel increment (0x70) read 1;
  - the three size registers read 0, which means one pixel by one line;
  - every other register reads 0;
  - `irqOut`, `lcdEnable`, `digEnable` and `invalidatePulse` are low.
- R4: `irqOut` is high exactly when the bitwise AND of status (0x0C) and enable (0x10) is nonzero. The new level appears in the cycle after the write or event that changed either register.
- R5: A write to status (0x0C) clears each bit written as 1 and leaves the rest. `frameDonePulse` sets status bit 0 at the clock edge where it is high. When a clear and the pulse fall in the same cycle, bit 0 ends up set.
- R6: The enable register (0x10) keeps bits 15:0 of the written value; bits 31:16 read as zero.
- R7: A write to 0x04 with bit 1 set returns every register to its R3 value and discards a `frameDonePulse` in that same cycle. Register 0x04 then holds the written value AND 0x301B. The same masked value is stored when bit 1 is clear, without the reset.
- R8: The control register (0x14) stores value AND 0x07FF9FFF. Bit 0 drives `lcdEnable` and bit 1 drives `digEnable`, from the cycle after the write.
- R9: The size registers are digital 0x48, LCD 0x4C and graphics 0x5C.
  - Each takes an X field at bits 10:0 and a Y field at bits 26:16.
  - Each field is held as a count equal to the field plus one.
  - A read returns ((ny−1)<<16)|(nx−1).
  - The graphics position register (0x58) keeps the same two 11-bit fields as written.
- R10: Write masks:
  - configuration 0x18: 0x3FFF;
  - capability 0x1C: 0x3FF;
  - colour keys 0x28/0x2C and default colours 0x20/0x24: 0xFFFFFF;
  - line number 0x34: 0x7FF;
  - horizontal and vertical timing 0x38/0x3C: 0x0FF0FF3F;
  - polarity/frequency 0x40: 0x3FFFF;
  - divisor 0x44: 0x00FF00FF;
  - attributes 0x60: 0x7FF;
  - FIFO threshold 0x64: 0x01FF01FF;
  - full 32 bits: base addresses 0x50/0x54, table base 0x78, row and pixel increments 0x6C/0x70, window skip 0x74.
- R11: `invalidatePulse` is high for one cycle, the cycle after an accepted write to any of these:
  - the configuration register;
  - any colour or colour-key register;
  - any size register;
  - graphics position or attributes;
  - either base address or the table base;
  - the row or pixel increment.

  After any other access it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Access request this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqSize | input | 2 | Access size code: 0 byte, 1 half, 2 word |
| reqAddr | input | 12 | Byte offset |
| reqWdata | input | 32 | Write data |
| frameDonePulse | input | 1 | Frame-done event, sets status bit 0 |
| rspRdata | output | 32 | Read data, valid in the request cycle |
| irqOut | output | 1 | Level interrupt |
| lcdEnable | output | 1 | LCD output enable (control bit 0) |
| digEnable | output | 1 | Digital output enable (control bit 1) |
| invalidatePulse | output | 1 | One-cycle redraw strobe |

## Verification
Two functions can meet in the same cycle, and each case has a required winner:
- A frame-done event and a write to the status register. The event set must survive the write-one-to-clear.
- A frame-done event and a soft reset. The event must be lost.

The bench provokes both cases directly: it drives `frameDonePulse` in the very cycle of the clearing write and of the reset write. It also raises the pulse at random during random traffic.

Each outcome is judged by reading back status at 0x0C and by watching `irqOut` in the following cycle. The expected values come from a bench model that applies the clear first and the set second, except when a reset occurs.

// File: rtl/dispreg_pkg.sv
package dispreg_pkg;

  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 12;
  localparam int FIELD_W  = 11;
  localparam int Y_LSB    = 16;
  localparam int IRQ_W    = 16;
  localparam int FRAME_BIT = 0;
  localparam int NUM_REGS = 32;
  localparam int IDX_W    = $clog2(NUM_REGS);

  localparam logic [1:0] SIZE_WORD = 2'd2;

  localparam logic [DATA_W-1:0] REV_VALUE     = 32'h0000_0020;
  localparam logic [DATA_W-1:0] SYSSTAT_VALUE = 32'h0000_0001;
  localparam logic [DATA_W-1:0] LINE_ST_VALUE = 32'h0000_07FF;
  localparam logic [DATA_W-1:0] FIFO_ST_VALUE = 32'd256;
  localparam logic [DATA_W-1:0] CAP_RESET     = 32'h0000_0161;

  localparam logic [DATA_W-1:0] FIELD_ONE  = (DATA_W'(1) << FIELD_W) - DATA_W'(1);
  localparam logic [DATA_W-1:0] PAIR_MASK  = FIELD_ONE | (FIELD_ONE << Y_LSB);
  localparam logic [DATA_W-1:0] IRQ_MASK   = (DATA_W'(1) << IRQ_W) - DATA_W'(1);
  localparam logic [DATA_W-1:0] COLOR_MASK = 32'h00FF_FFFF;

  // Word index = byte offset / 4.
  typedef enum logic [IDX_W-1:0] {
    R_REVISION  = 5'd0,  R_SYSCFG    = 5'd1,  R_SYSSTAT   = 5'd2,  R_IRQ_ST    = 5'd3,
    R_IRQ_EN    = 5'd4,  R_CONTROL   = 5'd5,  R_CONFIG    = 5'd6,  R_CAPAB     = 5'd7,
    R_BG0       = 5'd8,  R_BG1       = 5'd9,  R_KEY0      = 5'd10, R_KEY1      = 5'd11,
    R_LINE_ST   = 5'd12, R_LINE_NUM  = 5'd13, R_TIM_H     = 5'd14, R_TIM_V     = 5'd15,
    R_POLFREQ   = 5'd16, R_DIVISOR   = 5'd17, R_SIZE_DIG  = 5'd18, R_SIZE_LCD  = 5'd19,
    R_GFX_BASE0 = 5'd20, R_GFX_BASE1 = 5'd21, R_GFX_POS   = 5'd22, R_GFX_SIZE  = 5'd23,
    R_GFX_ATTR  = 5'd24, R_GFX_THR   = 5'd25, R_GFX_FIFOST = 5'd26, R_GFX_ROWINC = 5'd27,
    R_GFX_PIXINC = 5'd28, R_GFX_SKIP = 5'd29, R_GFX_TABLE = 5'd30, R_NONE      = 5'd31
  } regId_e;

  typedef struct packed {
    logic   wr;
    logic   rd;
    logic   softReset;
    logic   redraw;
    regId_e id;
  } strobe_t;

  // Registers held in a generic masked field.
  function automatic logic isPlain(regId_e id);
    case (id)
      R_REVISION, R_SYSSTAT, R_IRQ_ST, R_LINE_ST, R_SIZE_DIG, R_SIZE_LCD,
      R_GFX_SIZE, R_GFX_FIFOST, R_NONE: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] maskOf(regId_e id);
    case (id)
      R_SYSCFG:                     return 32'h0000_301B;
      R_IRQ_EN:                     return IRQ_MASK;
      R_CONTROL:                    return 32'h07FF_9FFF;
      R_CONFIG:                     return 32'h0000_3FFF;
      R_CAPAB:                      return 32'h0000_03FF;
      R_BG0, R_BG1, R_KEY0, R_KEY1: return COLOR_MASK;
      R_LINE_NUM:                   return FIELD_ONE;
      R_TIM_H, R_TIM_V:             return 32'h0FF0_FF3F;
      R_POLFREQ:                    return 32'h0003_FFFF;
      R_DIVISOR:                    return 32'h00FF_00FF;
      R_GFX_POS:                    return PAIR_MASK;
      R_GFX_ATTR:                   return 32'h0000_07FF;
      R_GFX_THR:                    return 32'h01FF_01FF;
      default:                      return '1;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] resetOf(regId_e id);
    case (id)
      R_CAPAB:                    return CAP_RESET;
      R_GFX_ROWINC, R_GFX_PIXINC: return DATA_W'(1);
      default:                    return '0;
    endcase
  endfunction

  // Registers whose change alters the displayed picture.
  function automatic logic isRedraw(regId_e id);
    case (id)
      R_CONFIG, R_BG0, R_BG1, R_KEY0, R_KEY1, R_SIZE_DIG, R_SIZE_LCD,
      R_GFX_BASE0, R_GFX_BASE1, R_GFX_POS, R_GFX_SIZE, R_GFX_ATTR,
      R_GFX_ROWINC, R_GFX_PIXINC, R_GFX_TABLE: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/dispreg_field.sv
module dispreg_field #(
  parameter int            W     = 32,
  parameter logic [W-1:0]  RESET = '0,
  parameter logic [W-1:0]  MASK  = '1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         clear,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  // A load wins over clear so that a register written in the reset cycle keeps its value.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      q <= RESET;
    else if (load)  q <= d & MASK;
    else if (clear) q <= RESET;
  end

endmodule

// File: rtl/dispreg_ctrl.sv
module dispreg_ctrl
  import dispreg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [1:0]        reqSize,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              resetBit,
  output strobe_t           strobe
);

  localparam int HI_LSB = IDX_W + 2;

  logic   legal;
  logic   inWindow;
  regId_e decId;

  assign legal    = reqValid && (reqSize == SIZE_WORD) && (reqAddr[1:0] == 2'b00);
  assign inWindow = (reqAddr[ADDR_W-1:HI_LSB] == '0);
  assign decId    = inWindow ? regId_e'(reqAddr[HI_LSB-1:2]) : R_NONE;

  always_comb begin
    strobe.id        = decId;
    strobe.wr        = legal && reqWrite && (decId != R_NONE);
    strobe.rd        = legal && !reqWrite;
    strobe.softReset = legal && reqWrite && (decId == R_SYSCFG) && resetBit;
    strobe.redraw    = legal && reqWrite && isRedraw(decId);
  end

  AST_NARROW_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqSize != SIZE_WORD) |-> (!strobe.wr && !strobe.rd && !strobe.softReset)); // R1

  AST_FAR_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqAddr[ADDR_W-1:HI_LSB] != '0) |-> (!strobe.wr && !strobe.redraw)); // R1

endmodule

// File: rtl/dispreg_datapath.sv
module dispreg_datapath
  import dispreg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [DATA_W-1:0] wdata,
  input  logic              frameDone,
  output logic [DATA_W-1:0] rdata,
  output logic              irqOut,
  output logic              lcdEnable,
  output logic              digEnable,
  output logic              invalidatePulse
);

  localparam int NUM_SIZE = 3;
  localparam logic [FIELD_W:0] COUNT_ONE = (FIELD_W+1)'(1);

  logic [NUM_REGS-1:0] wrSel;
  logic [DATA_W-1:0]   plainQ [NUM_REGS];
  logic [DATA_W-1:0]   sizeRd [NUM_SIZE];
  logic [IRQ_W-1:0]    irqStatus;
  logic [IRQ_W-1:0]    statusNext;
  logic [IRQ_W-1:0]    irqEnable;
  logic                redrawQ;

  assign wrSel = strobe.wr ? (NUM_REGS'(1) << strobe.id) : '0;

  // Generic masked registers, one per word index that holds plain state.
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_plain
    localparam regId_e ID = regId_e'(IDX_W'(g));
    if (isPlain(ID)) begin : g_fld
      dispreg_field #(
        .W     (DATA_W),
        .RESET (resetOf(ID)),
        .MASK  (maskOf(ID))
      ) u_fld (
        .clk   (clk),
        .rstN  (rstN),
        .clear (strobe.softReset),
        .load  (wrSel[g]),
        .d     (wdata),
        .q     (plainQ[g])
      );
    end else begin : g_none
      assign plainQ[g] = '0;
    end
  end

  // Panel and layer sizes are kept as counts (field + 1).
  for (genvar g = 0; g < NUM_SIZE; g++) begin : g_size
    localparam regId_e SID = (g == 0) ? R_SIZE_DIG : ((g == 1) ? R_SIZE_LCD : R_GFX_SIZE);
    logic [FIELD_W:0] nx, ny, nxm1, nym1;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        nx <= COUNT_ONE;
        ny <= COUNT_ONE;
      end else if (strobe.softReset) begin
        nx <= COUNT_ONE;
        ny <= COUNT_ONE;
      end else if (wrSel[SID]) begin
        nx <= {1'b0, wdata[FIELD_W-1:0]} + COUNT_ONE;
        ny <= {1'b0, wdata[Y_LSB +: FIELD_W]} + COUNT_ONE;
      end
    end

    assign nxm1      = nx - COUNT_ONE;
    assign nym1      = ny - COUNT_ONE;
    assign sizeRd[g] = DATA_W'(nxm1) | (DATA_W'(nym1) << Y_LSB);

    AST_SIZE_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
      (nx != '0) && (ny != '0)); // R9
  end

  // Event status: write-one-to-clear first, then the event sets its bit.
  always_comb begin
    statusNext = irqStatus;
    if (wrSel[R_IRQ_ST]) statusNext = statusNext & ~wdata[IRQ_W-1:0];
    if (frameDone)       statusNext[FRAME_BIT] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  irqStatus <= '0;
    else if (strobe.softReset)  irqStatus <= '0;
    else                        irqStatus <= statusNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) redrawQ <= 1'b0;
    else       redrawQ <= strobe.redraw;
  end

  assign irqEnable       = plainQ[R_IRQ_EN][IRQ_W-1:0];
  assign irqOut          = |(irqStatus & irqEnable);
  assign lcdEnable       = plainQ[R_CONTROL][0];
  assign digEnable       = plainQ[R_CONTROL][1];
  assign invalidatePulse = redrawQ;

  always_comb begin
    rdata = '0;
    if (strobe.rd) begin
      case (strobe.id)
        R_REVISION:   rdata = REV_VALUE;
        R_SYSSTAT:    rdata = SYSSTAT_VALUE;
        R_IRQ_ST:     rdata = DATA_W'(irqStatus);
        R_LINE_ST:    rdata = LINE_ST_VALUE;
        R_GFX_FIFOST: rdata = FIFO_ST_VALUE;
        R_SIZE_DIG:   rdata = sizeRd[0];
        R_SIZE_LCD:   rdata = sizeRd[1];
        R_GFX_SIZE:   rdata = sizeRd[2];
        default:      rdata = plainQ[strobe.id];
      endcase
    end
  end

  AST_STATUS_W1C: assert property (@(posedge clk) disable iff (!rstN)
    (wrSel[R_IRQ_ST] && !frameDone) |=> ((irqStatus & $past(wdata[IRQ_W-1:0])) == '0)); // R5

  AST_FRAME_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (frameDone && !strobe.softReset) |=> irqStatus[FRAME_BIT]); // R5

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    (wrSel[R_IRQ_EN] && wdata[IRQ_W-1:0] == '0) |=> !irqOut); // R4

  AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rstN)
    strobe.softReset |=> (!lcdEnable && !digEnable && !irqOut && irqStatus == '0)); // R7

  AST_OUT_ENABLES: assert property (@(posedge clk) disable iff (!rstN)
    wrSel[R_CONTROL] |=> (lcdEnable == $past(wdata[0]) && digEnable == $past(wdata[1]))); // R8

  AST_REDRAW_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    invalidatePulse |-> $past(strobe.wr)); // R11

endmodule

// File: rtl/dispreg_top.sv
module dispreg_top
  import dispreg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [1:0]        reqSize,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              frameDonePulse,
  output logic [DATA_W-1:0] rspRdata,
  output logic              irqOut,
  output logic              lcdEnable,
  output logic              digEnable,
  output logic              invalidatePulse
);

  strobe_t strobe;

  dispreg_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqSize  (reqSize),
    .reqAddr  (reqAddr),
    .resetBit (reqWdata[1]),
    .strobe   (strobe)
  );

  dispreg_datapath u_dp (
    .clk             (clk),
    .rstN            (rstN),
    .strobe          (strobe),
    .wdata           (reqWdata),
    .frameDone       (frameDonePulse),
    .rdata           (rspRdata),
    .irqOut          (irqOut),
    .lcdEnable       (lcdEnable),
    .digEnable       (digEnable),
    .invalidatePulse (invalidatePulse)
  );

endmodule

// File: tb/test_dispreg_top.sv
`timescale 1ns/100ps
module test_dispreg_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [1:0]  reqSize = 2'd2;
  logic [11:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic        frameDonePulse = 1'b0;
  logic [31:0] rspRdata;
  logic        irqOut, lcdEnable, digEnable, invalidatePulse;

  int compared = 0;
  int mismatched = 0;

  logic [31:0] m [32];
  logic [15:0] mSt;

  always #2.5 clk = ~clk;

  dispreg_top i_dispreg_top (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqSize(reqSize), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .frameDonePulse(frameDonePulse), .rspRdata(rspRdata), .irqOut(irqOut),
    .lcdEnable(lcdEnable), .digEnable(digEnable), .invalidatePulse(invalidatePulse)
  );

  function automatic logic [31:0] wmask(int i);
    case (i)
      1: return 32'h0000_301B;
      4: return 32'h0000_FFFF;
      5: return 32'h07FF_9FFF;
      6: return 32'h0000_3FFF;
      7: return 32'h0000_03FF;
      8, 9, 10, 11: return 32'h00FF_FFFF;
      13, 24: return 32'h0000_07FF;
      14, 15: return 32'h0FF0_FF3F;
      16: return 32'h0003_FFFF;
      17: return 32'h00FF_00FF;
      18, 19, 22, 23: return 32'h07FF_07FF;
      25: return 32'h01FF_01FF;
      0, 2, 3, 12, 26, 31: return 32'h0;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic benchRedraw(int i);
    case (i)
      6, 8, 9, 10, 11, 18, 19, 20, 21, 22, 23, 24, 27, 28, 30: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] expRead(int i);
    case (i)
      0: return 32'h20;
      2: return 32'h1;
      3: return {16'h0, mSt};
      12: return 32'h7FF;
      26: return 32'd256;
      31: return 32'h0;
      default: return m[i];
    endcase
  endfunction

  function automatic string tagFor(int i);
    case (i)
      0, 2, 12, 26: return "R2";
      3: return "R5";
      4: return "R6";
      1: return "R7";
      5: return "R8";
      18, 19, 22, 23: return "R9";
      31: return "R1";
      default: return "R10";
    endcase
  endfunction

  task automatic modelReset();
    for (int i = 0; i < 32; i++) m[i] = 32'h0;
    m[7]  = 32'h161;
    m[27] = 32'h1;
    m[28] = 32'h1;
    mSt   = 16'h0;
  endtask

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic checkOutputs(input logic expInv);
    chk("R11", "invalidatePulse", {31'h0, invalidatePulse}, {31'h0, expInv});
    chk("R4",  "irqOut", {31'h0, irqOut}, {31'h0, |(mSt & m[4][15:0])});
    chk("R8",  "lcdEnable", {31'h0, lcdEnable}, {31'h0, m[5][0]});
    chk("R8",  "digEnable", {31'h0, digEnable}, {31'h0, m[5][1]});
  endtask

  task automatic doWrite(input logic [11:0] addr, input logic [31:0] data,
                         input logic [1:0] size, input logic frame);
    logic legal;
    int   idx;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqSize = size; reqAddr = addr;
    reqWdata = data; frameDonePulse = frame;
    @(negedge clk);
    reqValid = 1'b0; frameDonePulse = 1'b0;
    idx   = int'(addr[6:2]);
    legal = (size == 2'd2) && (addr[1:0] == 2'b00) && (addr < 12'h080) && (idx != 31);
    if (legal && idx == 1 && data[1]) begin
      modelReset();
      m[1] = data & 32'h0000_301B;
    end else begin
      if (legal && idx == 3) mSt = mSt & ~data[15:0];
      else if (legal) m[idx] = data & wmask(idx);
      if (frame) mSt[0] = 1'b1;
    end
    checkOutputs(legal && benchRedraw(idx));
  endtask

  task automatic doRead(input logic [11:0] addr, input logic [1:0] size, input string tagOver);
    logic        legal;
    int          idx;
    logic [31:0] exp;
    string       tag;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqSize = size; reqAddr = addr; frameDonePulse = 1'b0;
    #1;
    idx   = int'(addr[6:2]);
    legal = (size == 2'd2) && (addr[1:0] == 2'b00) && (addr < 12'h080);
    exp   = legal ? expRead(idx) : 32'h0;
    tag   = (tagOver != "") ? tagOver : (legal ? tagFor(idx) : "R1");
    chk(tag, $sformatf("read @%h", addr), rspRdata, exp);
    reqValid = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    mismatched++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h0D15_9A7E);
    modelReset();
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R3: reset state of every word and of the outputs
    @(negedge clk);
    checkOutputs(1'b0);
    for (int i = 0; i < 32; i++) doRead(12'(i * 4), 2'd2, "R3");

    // R1: narrow, misaligned and undefined accesses
    doWrite(12'h014, 32'h0000_0003, 2'd1, 1'b0);
    doRead (12'h014, 2'd2, "R1");
    doRead (12'h000, 2'd1, "R1");
    doWrite(12'h016, 32'hFFFF_FFFF, 2'd2, 1'b0);
    doWrite(12'h100, 32'hFFFF_FFFF, 2'd2, 1'b0);
    doRead (12'h100, 2'd2, "R1");
    doWrite(12'h07C, 32'hFFFF_FFFF, 2'd2, 1'b0);
    doRead (12'h07C, 2'd2, "R1");

    // R2: constant registers ignore writes
    doWrite(12'h000, 32'hFFFF_FFFF, 2'd2, 1'b0);
    doRead (12'h000, 2'd2, "R2");

    // R9: size field boundaries
    doWrite(12'h04C, 32'hFFFF_FFFF, 2'd2, 1'b0);
    doRead (12'h04C, 2'd2, "R9");
    doWrite(12'h05C, 32'h0000_0000, 2'd2, 1'b0);
    doRead (12'h05C, 2'd2, "R9");

    // R6: enable keeps low half only
    doWrite(12'h010, 32'hFFFF_FFFF, 2'd2, 1'b0);
    doRead (12'h010, 2'd2, "R6");

    // R5 / R4: event sets status, clear coinciding with event keeps bit 0
    doWrite(12'h100, 32'h0, 2'd2, 1'b1);
    doRead (12'h00C, 2'd2, "R5");
    doWrite(12'h00C, 32'hFFFF_FFFF, 2'd2, 1'b1);
    doRead (12'h00C, 2'd2, "R5");
    doWrite(12'h00C, 32'h0000_0001, 2'd2, 1'b0);
    doRead (12'h00C, 2'd2, "R5");

    // R8: output enables follow control
    doWrite(12'h014, 32'hFFFF_FFFF, 2'd2, 1'b0);
    doRead (12'h014, 2'd2, "R8");

    // R7: soft reset in the same cycle as an event
    doWrite(12'h100, 32'h0, 2'd2, 1'b1);
    doWrite(12'h004, 32'hFFFF_FFFF, 2'd2, 1'b1);
    for (int i = 0; i < 32; i++) doRead(12'(i * 4), 2'd2, "R7");

    // Random traffic
    for (int n = 0; n < 800; n++) begin
      int unsigned op;
      int unsigned idx;
      logic        frame;
      op    = $urandom % 8;
      idx   = $urandom % 32;
      frame = ($urandom % 6) == 0;
      case (op)
        0, 1, 2, 3: doWrite(12'(idx * 4), $urandom, 2'd2, frame);
        4, 5:       doRead (12'(idx * 4), 2'd2, "");
        6:          doWrite(12'(idx * 4), $urandom, 2'($urandom % 2), frame);
        default:    doRead (12'h100 + 12'(idx * 4), 2'd2, "R1");
      endcase
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule